// File: doc/BRIEF.md
# Dual Cascadable Interval Timer with Square-Wave Outputs

This block holds two up-counting interval timers, A and B, each with its own compare register and count-clock selector. A timer in run mode counts enable pulses from its selected source. When the count equals the compare value, the next pulse clears the counter, toggles the timer's square-wave output and sets a sticky interrupt flag. One interval therefore lasts compare+1 count periods. The output period is two intervals. The sequence repeats for as long as the compare value stays the same.

Count pulses come from a free-running prescaler that is advanced only by the instruction-cycle strobe. It has taps every 2, 32 or 512 instruction cycles. Timer A can also count rising edges of an external pin, taken through a two-flop synchronizer and an edge detector. With the cascade input set, the two timers form one 16-bit counter. A is the low byte and sets the clock source and the run control. B advances only on A's carry. The combined match drives A's output and A's flag, while B's output and flag hold.

Each timer is controlled by a two-state machine. CH_IDLE holds the counter at zero and leaves the output alone. The move CH_IDLE→CH_COUNT happens when the run input is high. The move CH_COUNT→CH_IDLE happens when the run input drops, and the counter is cleared at that point. Only CH_COUNT acts on count pulses.

Top module: `dual_interval_timer`

## Requirements
- R1: Selector codes 00, 01 and 10 give count periods of 2, 32 and 512 instruction cycles, for both timers.
- R2: The prescaler advances only on cycles with `inst_en` high. A half-rate strobe therefore doubles every interval measured in clock cycles.
- R3: With compare value N, the square-wave output toggles once every N+1 count periods. This repeats without any software action, and N=0 toggles on every count period.
- R4: For timer A, selector code 11 counts synchronized rising edges of `ext_clk_pin`. With the pin static, no toggle occurs.
- R5: For timer B, selector code 11 selects no source: B does not count and `sq_b` holds.
- R6: Each interval end sets the timer's interrupt flag, in the same cycle as its toggle. A write of zero to the timer's flag address clears the flag. A non-zero write to that address leaves the flag set.
- R7: When the run input goes low, the counter clears and the output keeps its level. When the run input goes high again, counting resumes with the same interval.
- R8: With `cascade` high, the interval is ({cmp B, cmp A})+1 periods of A's source. B advances on A's carry from 0xFF. The toggles and flag appear on `sq_a`/`irq_a`, and `sq_b`/`irq_b` hold.
- R9: After reset, all outputs are low, both compare values are zero and both counters are stopped.
- R10: Write address map: 0 holds A's compare value and 1 holds B's compare value. Address 2 is A's flag-clear address and address 3 is B's flag-clear address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inst_en | input | 1 | Instruction-cycle strobe |
| ext_clk_pin | input | 1 | Asynchronous external count clock (timer A) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address (see R10) |
| wr_data | input | CNT_W | Register write data |
| run_a | input | 1 | Run control, timer A (and the cascaded pair) |
| run_b | input | 1 | Run control, timer B in 8-bit mode |
| cascade | input | 1 | 1 = join A and B into one 16-bit timer |
| sel_a | input | 2 | Count-clock select, timer A |
| sel_b | input | 2 | Count-clock select, timer B |
| sq_a | output | 1 | Square-wave output, timer A / cascaded pair |
| sq_b | output | 1 | Square-wave output, timer B |
| irq_a | output | 1 | Sticky interrupt flag, timer A / cascaded pair |
| irq_b | output | 1 | Sticky interrupt flag, timer B |

## Verification
The bench measures the clock-cycle gap between consecutive toggles. Each source is tried in turn: each prescaler tap, a half-rate instruction strobe and a periodic external pin. Each of these gives a distinct expected gap, so a wrong tap, a count of clocks in place of strobes or a missed edge produces a different number. Cascaded runs use compare pairs whose 16-bit value differs from either byte alone, including one that needs a low-byte carry. This separates a true 16-bit compare from a low-byte-only compare. Silent cases (static pin, B on code 11, stopped timer, cascaded B outputs) are observed over a long window in which a toggle would otherwise occur.

// File: rtl/dit_pkg.sv
package dit_pkg;

    typedef enum logic [1:0] {
        CK_DIV2   = 2'b00,
        CK_DIV32  = 2'b01,
        CK_DIV512 = 2'b10,
        CK_EXT    = 2'b11
    } clk_sel_e;

    typedef enum logic [0:0] {
        CH_IDLE  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_e;

    localparam logic [1:0] ADDR_CMP_A = 2'd0;
    localparam logic [1:0] ADDR_CMP_B = 2'd1;
    localparam logic [1:0] ADDR_FLG_A = 2'd2;
    localparam logic [1:0] ADDR_FLG_B = 2'd3;

    localparam int NUM_CH   = 2;
    localparam int NUM_TAPS = 3;

endpackage

// File: rtl/dit_prescaler.sv
module dit_prescaler #(
    parameter int SH_LO  = 1,
    parameter int SH_MID = 5,
    parameter int SH_HI  = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inst_en,
    output logic [2:0] taps
);
    localparam int DIV_W = SH_HI;

    logic [DIV_W-1:0] div_q;

    function automatic int shift_of(input int idx);
        case (idx)
            0:       return SH_LO;
            1:       return SH_MID;
            default: return SH_HI;
        endcase
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (inst_en) begin
            div_q <= div_q + 1'b1;
        end
    end

    // each tap fires on the strobe that rolls its low bits over
    for (genvar gt = 0; gt < 3; gt++) begin : g_tap
        localparam int SH = shift_of(gt);
        assign taps[gt] = inst_en && (&div_q[SH-1:0]);
    end

endmodule

// File: rtl/dit_edge_sync.sv
module dit_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic pulse
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[SH_W-2:0], pin};
        end
    end

    // one-cycle pulse on a synchronized low-to-high change
    assign pulse = shift_q[SH_W-2] & ~shift_q[SH_W-1];

endmodule

// File: rtl/dit_channel.sv
module dit_channel
    import dit_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             hit,
    input  logic             quiet,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             sq,
    output logic             irq
);
    ch_state_e state_q, state_d;
    logic      end_evt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:  if (run)  state_d = CH_COUNT;
            CH_COUNT: if (!run) state_d = CH_IDLE;
            default:            state_d = CH_IDLE;
        endcase
    end

    assign end_evt = (state_q == CH_COUNT) && run && tick && hit;

    // outputs: counter, toggle, flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            sq    <= 1'b0;
            irq   <= 1'b0;
        end else begin
            unique case (state_q)
                CH_IDLE: begin
                    count <= '0;
                end
                CH_COUNT: begin
                    if (!run) begin
                        count <= '0;
                    end else if (tick) begin
                        if (hit) begin
                            count <= '0;
                            if (!quiet) sq <= ~sq;
                        end else begin
                            count <= count + 1'b1;
                        end
                    end
                end
                default: count <= '0;
            endcase

            if (end_evt && !quiet) begin
                irq <= 1'b1;
            end else if (flag_clr) begin
                irq <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int         CNT_W    = 8,
    parameter int         SH_LO    = 1,
    parameter int         SH_MID   = 5,
    parameter int         SH_HI    = 9,
    parameter logic [1:0] EXT_MASK = 2'b01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inst_en,
    input  logic             ext_clk_pin,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             run_a,
    input  logic             run_b,
    input  logic             cascade,
    input  logic [1:0]       sel_a,
    input  logic [1:0]       sel_b,
    output logic             sq_a,
    output logic             sq_b,
    output logic             irq_a,
    output logic             irq_b
);
    localparam int WIDE_W = 2 * CNT_W;

    logic [2:0]        taps;
    logic              ext_pulse;
    logic [CNT_W-1:0]  cmp_q [NUM_CH];
    logic [CNT_W-1:0]  cnt_v [NUM_CH];
    logic [1:0]        sel_v [NUM_CH];
    logic [NUM_CH-1:0] tick_src, ch_tick, ch_hit, ch_run, ch_quiet, ch_clr;
    logic [NUM_CH-1:0] ch_sq, ch_irq, hit8;
    logic              hit16, low_full;

    dit_prescaler #(.SH_LO(SH_LO), .SH_MID(SH_MID), .SH_HI(SH_HI)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .inst_en (inst_en),
        .taps    (taps)
    );

    dit_edge_sync #(.SYNC_STAGES(2)) u_ext (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_clk_pin),
        .pulse (ext_pulse)
    );

    assign sel_v[0] = sel_a;
    assign sel_v[1] = sel_b;

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_reg
        localparam logic [1:0] CMP_ADDR = ADDR_CMP_A + 2'(gi);
        localparam logic [1:0] FLG_ADDR = ADDR_FLG_A + 2'(gi);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_q[gi] <= '0;
            end else if (wr_en && wr_addr == CMP_ADDR) begin
                cmp_q[gi] <= wr_data;
            end
        end

        assign ch_clr[gi] = wr_en && (wr_addr == FLG_ADDR) && (wr_data == '0);

        // count source: prescaler tap or, where fitted, the external pin
        assign tick_src[gi] =
            (sel_v[gi] == CK_DIV2)   ? taps[0] :
            (sel_v[gi] == CK_DIV32)  ? taps[1] :
            (sel_v[gi] == CK_DIV512) ? taps[2] :
            (EXT_MASK[gi] ? ext_pulse : 1'b0);

        assign hit8[gi] = (cnt_v[gi] == cmp_q[gi]);
    end

    assign hit16    = ({cnt_v[1], cnt_v[0]} == WIDE_W'({cmp_q[1], cmp_q[0]}));
    assign low_full = &cnt_v[0];

    // pair wiring: B follows A's source and run control when joined
    assign ch_tick[0]  = tick_src[0];
    assign ch_tick[1]  = cascade ? (tick_src[0] && (low_full || hit16)) : tick_src[1];
    assign ch_hit[0]   = cascade ? hit16 : hit8[0];
    assign ch_hit[1]   = cascade ? hit16 : hit8[1];
    assign ch_run[0]   = run_a;
    assign ch_run[1]   = cascade ? run_a : run_b;
    assign ch_quiet[0] = 1'b0;
    assign ch_quiet[1] = cascade;

    for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_ch
        dit_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (ch_run[gc]),
            .tick     (ch_tick[gc]),
            .hit      (ch_hit[gc]),
            .quiet    (ch_quiet[gc]),
            .flag_clr (ch_clr[gc]),
            .count    (cnt_v[gc]),
            .sq       (ch_sq[gc]),
            .irq      (ch_irq[gc])
        );
    end

    assign sq_a  = ch_sq[0];
    assign sq_b  = ch_sq[1];
    assign irq_a = ch_irq[0];
    assign irq_b = ch_irq[1];

endmodule

// File: rtl/dual_interval_timer_chk.sv
module dual_interval_timer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_a,
    input logic         run_a,
    input logic         cascade,
    input logic [1:0]   sel_b,
    input logic         wr_en,
    input logic [1:0]   wr_addr,
    input logic [W-1:0] wr_data,
    input logic         sq_a,
    input logic         sq_b,
    input logic         irq_a,
    input logic         irq_b
);

    AST_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sq_a) |-> $past(tick_a)); // R3

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_a) |-> $stable(sq_a)); // R7

    AST_B_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_b == 2'd3 && !cascade) |-> $stable(sq_b)); // R5

    AST_CASCADE_QUIET_B: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cascade) |-> ($stable(sq_b) && !$rose(irq_b))); // R8

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_a) && !($past(wr_en) && $past(wr_addr) == 2'd2 && $past(wr_data) == '0))
        |-> irq_a); // R6

    AST_IRQ_WITH_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_a) |-> !$stable(sq_a)); // R6

endmodule

bind dual_interval_timer dual_interval_timer_chk #(.W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_a  (ch_tick[0]),
    .run_a   (run_a),
    .cascade (cascade),
    .sel_b   (sel_b),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sq_a    (sq_a),
    .sq_b    (sq_b),
    .irq_a   (irq_a),
    .irq_b   (irq_b)
);

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inst_en = 1'b1;
    logic       ext_clk_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       run_a = 1'b0, run_b = 1'b0, cascade = 1'b0;
    logic [1:0] sel_a = 2'b00, sel_b = 2'b00;
    logic       sq_a, sq_b, irq_a, irq_b;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    bit  half_rate = 1'b0;
    bit  ext_on = 1'b0;
    int  ext_cnt = 0;

    always #10 clk = ~clk; // 50 MHz

    dual_interval_timer u_dual_interval_timer (
        .clk(clk), .rst_n(rst_n), .inst_en(inst_en), .ext_clk_pin(ext_clk_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .run_a(run_a), .run_b(run_b), .cascade(cascade),
        .sel_a(sel_a), .sel_b(sel_b),
        .sq_a(sq_a), .sq_b(sq_b), .irq_a(irq_a), .irq_b(irq_b)
    );

    // strobe and external pin generation, driven away from the active edge
    always @(negedge clk) begin
        inst_en <= half_rate ? ~inst_en : 1'b1;
        if (ext_on) begin
            ext_cnt <= (ext_cnt == 7) ? 0 : ext_cnt + 1;
            ext_clk_pin <= (ext_cnt < 4);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic pick(input int ch);
        return (ch == 0) ? sq_a : sq_b;
    endfunction

    // cycles until the chosen output changes, -1 if none within limit
    task automatic wait_toggle(input int ch, input int limit, output int n);
        logic prev = pick(ch);
        n = 0;
        while (pick(ch) == prev && n < limit) begin
            @(negedge clk);
            n++;
        end
        if (pick(ch) == prev) n = -1;
    endtask

    task automatic measure(input int ch, input int limit, output int gap);
        int dummy;
        wait_toggle(ch, limit, dummy);
        wait_toggle(ch, limit, gap);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic stop_all();
        @(negedge clk);
        run_a = 1'b0; run_b = 1'b0; cascade = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R9 sq_a after reset", sq_a, 0);
        chk("R9 sq_b after reset", sq_b, 0);
        chk("R9 irq_a after reset", irq_a, 0);
        chk("R9 irq_b after reset", irq_b, 0);
    endtask

    task automatic t_div2_irq_stop();
        int g;
        logic lvl;
        reg_wr(2'd0, 8'd5); // R10 compare A at address 0
        sel_a = 2'b00; run_a = 1'b1;
        measure(0, 200, g);
        chk("R1/R3 div2 cmp5 gap", g, 12);
        wait_toggle(0, 200, g);
        chk("R3 interval repeats", g, 12);
        chk("R6 irq_a set after interval", irq_a, 1);
        // stop, then output must hold
        @(negedge clk); run_a = 1'b0;
        @(negedge clk); lvl = sq_a;
        wait_toggle(0, 300, g);
        chk("R7 output holds while stopped", g, -1);
        chk("R7 level kept", sq_a, lvl);
        reg_wr(2'd2, 8'd1);
        chk("R6 nonzero write keeps flag", irq_a, 1);
        reg_wr(2'd2, 8'd0);
        chk("R6 zero write clears flag", irq_a, 0);
        @(negedge clk); run_a = 1'b1;
        measure(0, 200, g);
        chk("R7 restart same interval", g, 12);
        stop_all();
    endtask

    task automatic t_taps();
        int g;
        reg_wr(2'd0, 8'd1);
        sel_a = 2'b01; run_a = 1'b1;
        measure(0, 400, g);
        chk("R1 div32 cmp1 gap", g, 64);
        stop_all();
        reg_wr(2'd0, 8'd0);
        sel_a = 2'b10; run_a = 1'b1;
        measure(0, 2000, g);
        chk("R1/R3 div512 cmp0 gap", g, 512);
        stop_all();
    endtask

    task automatic t_strobe();
        int g;
        half_rate = 1'b1;
        reg_wr(2'd0, 8'd5);
        sel_a = 2'b00; run_a = 1'b1;
        measure(0, 400, g);
        chk("R2 half-rate strobe doubles gap", g, 24);
        stop_all();
        half_rate = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_ext();
        int g;
        reg_wr(2'd0, 8'd3);
        sel_a = 2'b11; run_a = 1'b1;
        wait_toggle(0, 300, g);
        chk("R4 static pin gives no toggle", g, -1);
        ext_on = 1'b1;
        measure(0, 400, g);
        chk("R4 ext edges cmp3 gap", g, 32);
        stop_all();
        ext_on = 1'b0;
    endtask

    task automatic t_timer_b();
        int g;
        reg_wr(2'd1, 8'd0); // R10 compare B at address 1
        sel_b = 2'b11; run_b = 1'b1; ext_on = 1'b1;
        wait_toggle(1, 2000, g);
        chk("R5 timer B code 11 silent", g, -1);
        chk("R5 irq_b stays low", irq_b, 0);
        ext_on = 1'b0;
        stop_all();
        reg_wr(2'd1, 8'd2);
        sel_b = 2'b01; run_b = 1'b1;
        measure(1, 400, g);
        chk("R1 timer B div32 cmp2 gap", g, 96);
        chk("R6 irq_b set", irq_b, 1);
        stop_all();
        reg_wr(2'd3, 8'd0);
        chk("R10 flag B cleared at address 3", irq_b, 0);
    endtask

    task automatic t_cascade();
        int g;
        logic lvl_b;
        lvl_b = sq_b;
        reg_wr(2'd0, 8'd2);
        reg_wr(2'd1, 8'd1);
        sel_a = 2'b00; sel_b = 2'b11; cascade = 1'b1; run_a = 1'b1;
        measure(0, 2000, g);
        chk("R8 cascade 0x0102 gap", g, 518);
        chk("R8 sq_b holds in cascade", sq_b, lvl_b);
        chk("R8 irq_b stays low", irq_b, 0);
        chk("R8 irq_a set", irq_a, 1);
        stop_all();
        reg_wr(2'd0, 8'hFF);
        cascade = 1'b1; run_a = 1'b1;
        measure(0, 3000, g);
        chk("R8 cascade 0x01FF carry gap", g, 1024);
        stop_all();
        reg_wr(2'd0, 8'd0);
        reg_wr(2'd1, 8'd0);
        cascade = 1'b1; run_a = 1'b1;
        measure(0, 100, g);
        chk("R8/R3 cascade zero compare gap", g, 2);
        stop_all();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_div2_irq_stop();
        t_taps();
        t_strobe();
        t_ext();
        t_timer_b();
        t_cascade();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule